// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns one asynchronous serial line back into characters. A sampling enable, `tick_i`, pulses at sixteen times the baud rate. The line is first passed through a two-flop synchroniser. A falling edge starts a candidate start bit. The candidate is accepted only if the line stays low up to the middle of that bit; otherwise it is dropped. Once a start is accepted, every later bit (data, optional parity, stop) is sampled once, sixteen ticks after the previous sample, which places each sample at the centre of its bit.

The character length, bit order and parity mode come from static configuration inputs that use the same codes as the matching transmitter. The configuration is latched when the falling edge is seen. A received character appears right-justified on a 9-bit bus with a one-cycle strobe. A parity-error flag and a framing-error flag are valid in the same cycle as the strobe.

Only a single stop bit is ever checked. The receiver goes back to hunting as soon as that stop sample is taken, so it stays in step with a sender that uses shorter stop periods than configured.

Top module: `serial_rx_x16`

## Requirements
- R1: After reset, `valid_o`, `par_err_o` and `frame_err_o` are 0, `data_o` is 0, and the receiver is hunting for a start bit.
- R2: A start is only accepted if the synchronised line is sampled low on 8 consecutive ticks, beginning with the first low sample after a high one. A high sample before the 8th rejects the start, and no character is produced.
- R3: Each data, parity and stop bit is sampled exactly once, 16 ticks after the previous sample (tick 8 of its own period). Line values at other ticks of the bit have no effect.
- R4: Data length: `nine_bit_i`=1 selects 9 bits. Otherwise `len_sel_i` 0, 1, 2, 3 selects 5, 6, 7, 8 bits. `data_o` is right-justified, and bits at and above the length read 0.
- R5: With `msb_first_i`=0, the first data bit received lands in `data_o[0]`. With `msb_first_i`=1, it lands in `data_o[len-1]`.
- R6: `par_sel_i` codes: 0 = even, 1 = odd, 2 = parity bit forced 0, 3 = parity bit forced 1, 4 to 7 = no parity bit. When a received parity bit differs from the expected value, `par_err_o`=1. When there is no parity bit, `par_err_o` stays 0.
- R7: Exactly one stop bit is sampled. If that sample is low, `frame_err_o`=1.
- R8: Hunting resumes right after the stop sample. A falling edge on the very next tick starts a new character, so stop periods of 9 ticks or more are received without loss.
- R9: `valid_o` is a one-cycle pulse per character. `par_err_o` and `frame_err_o` are only ever 1 in a cycle where `valid_o` is 1.
- R10: A start needs a high-to-low transition. If the line stays low after a low stop sample, no further character is produced until the line has been high for at least one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling enable, 16 pulses per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Character length select (5 to 8 bits) |
| nine_bit_i | input | 1 | Selects a 9-bit character |
| msb_first_i | input | 1 | Bit order: 1 = most significant bit first |
| par_sel_i | input | 3 | Parity mode |
| data_o | output | 9 | Received character, right-justified |
| valid_o | output | 1 | One-cycle character strobe |
| par_err_o | output | 1 | Parity mismatch, qualified by `valid_o` |
| frame_err_o | output | 1 | Stop bit sampled low, qualified by `valid_o` |

## Verification
A wrong sample counter or bit index shows up on the very next strobe. The data comes back shifted or with bits swapped, the parity flag fires on clean frames, or a frame with short stop bits is dropped. A broken start filter shows at the ports within one character time, as a character appearing after a short low glitch. A missing edge requirement shows as a stream of characters with framing errors while the line is held low. Glitches placed near bit edges expose sampling at any tick other than the centre.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       msb_first;
    logic [2:0] par_mode;
  } rx_cfg_t;

  localparam logic [1:0] PM_EVEN = 2'd0;
  localparam logic [1:0] PM_ODD  = 2'd1;
  localparam logic [1:0] PM_ZERO = 2'd2;
  localparam logic [1:0] PM_ONE  = 2'd3;

  function automatic logic [3:0] char_bits(input logic [1:0] len_sel, input logic nine);
    return nine ? 4'd9 : 4'd5 + {2'b00, len_sel};
  endfunction

  function automatic logic par_enabled(input logic [2:0] mode);
    return !mode[2];
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  rx_cfg_t          cfg_i,
  output rx_cfg_t          cfg_o,
  output logic             start_o,
  output logic             bit_stb_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             par_stb_o,
  output logic             stop_stb_o
);

  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             prev_q;
  rx_cfg_t          cfg_q;
  logic             centre;
  logic [IDX_W-1:0] last_idx;

  assign centre   = tick_i && (cnt_q == CNT_LAST);
  assign last_idx = IDX_W'(cfg_q.nbits - 4'd1);

  always_comb begin
    start_o    = (state_q == ST_START) && tick_i && !rx_i && (cnt_q == CNT_MID);
    bit_stb_o  = (state_q == ST_DATA) && centre;
    par_stb_o  = (state_q == ST_PAR) && centre;
    stop_stb_o = (state_q == ST_STOP) && centre;
  end

  assign bit_idx_o = idx_q;
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b1;
      cfg_q   <= '0;
    end else if (tick_i) begin
      prev_q <= rx_i;
      unique case (state_q)
        ST_IDLE: begin
          if (prev_q && !rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            cfg_q   <= cfg_i;
          end
        end
        ST_START: begin
          if (rx_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (cnt_q == CNT_MID) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == last_idx)
              state_q <= par_enabled(cfg_q.par_mode) ? ST_PAR : ST_STOP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && rx_i) |=> (state_q == ST_IDLE)); // R2
  AST_STOP_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_stb_o |=> (state_q == ST_IDLE)); // R8
  AST_EDGE_NEEDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tick_i && !prev_q) |=> (state_q == ST_IDLE)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, bit_stb_o, par_stb_o, stop_stb_o})); // R3

endmodule

// File: rtl/rx_assembler.sv
module rx_assembler
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  rx_cfg_t           cfg_i,
  input  logic              start_i,
  input  logic              bit_stb_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              par_stb_i,
  input  logic              stop_stb_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frame_err_o
);

  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              exp_par;
  logic [IDX_W-1:0]  pos;

  assign pos = cfg_i.msb_first ? IDX_W'(cfg_i.nbits - 4'd1) - bit_idx_i : bit_idx_i;

  always_comb begin
    unique case (cfg_i.par_mode[1:0])
      PM_EVEN: exp_par = ^shreg_q;
      PM_ODD:  exp_par = ~^shreg_q;
      PM_ZERO: exp_par = 1'b0;
      default: exp_par = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      par_q       <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      if (start_i) shreg_q <= '0;
      if (bit_stb_i && (int'(pos) < DATA_W)) shreg_q[pos] <= rx_i;
      if (par_stb_i) par_q <= rx_i;
      valid_o <= stop_stb_i;
      if (stop_stb_i) begin
        data_o      <= shreg_q;
        frame_err_o <= !rx_i;
        par_err_o   <= par_enabled(cfg_i.par_mode) && (par_q != exp_par);
      end else begin
        frame_err_o <= 1'b0;
        par_err_o   <= 1'b0;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_FLAG_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frame_err_o) |-> valid_o); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> cfg_i.nbits) == '0)); // R4
  AST_NO_PARITY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_i.par_mode[2]) |-> !par_err_o); // R6

endmodule

// File: rtl/serial_rx_x16.sv
module serial_rx_x16
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        len_sel_i,
  input  logic              nine_bit_i,
  input  logic              msb_first_i,
  input  logic [2:0]        par_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frame_err_o
);

  localparam int IDX_W = $clog2(DATA_W) + 1;

  logic             rx_s;
  rx_cfg_t          cfg_live, cfg_frame;
  logic             start_p, bit_p, par_p, stop_p;
  logic [IDX_W-1:0] bit_idx;

  always_comb begin
    cfg_live.nbits     = char_bits(len_sel_i, nine_bit_i);
    cfg_live.msb_first = msb_first_i;
    cfg_live.par_mode  = par_sel_i;
  end

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rx_frame_fsm #(.OS_RATE(OS_RATE), .IDX_W(IDX_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .cfg_i     (cfg_live),
    .cfg_o     (cfg_frame),
    .start_o   (start_p),
    .bit_stb_o (bit_p),
    .bit_idx_o (bit_idx),
    .par_stb_o (par_p),
    .stop_stb_o(stop_p)
  );

  rx_assembler #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_s),
    .cfg_i      (cfg_frame),
    .start_i    (start_p),
    .bit_stb_i  (bit_p),
    .bit_idx_i  (bit_idx),
    .par_stb_i  (par_p),
    .stop_stb_i (stop_p),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .par_err_o  (par_err_o),
    .frame_err_o(frame_err_o)
  );

endmodule

// File: tb/serial_rx_x16_test.sv
module serial_rx_x16_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] len_sel_i = 2'd3;
  logic       nine_bit_i = 1'b0;
  logic       msb_first_i = 1'b0;
  logic [2:0] par_sel_i = 3'd4;
  logic [8:0] data_o;
  logic       valid_o, par_err_o, frame_err_o;

  int n_checks = 0;
  int n_fail = 0;
  int got_n = 0;
  logic [8:0] got_d;
  logic got_pe, got_fe;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  serial_rx_x16 uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .len_sel_i(len_sel_i), .nine_bit_i(nine_bit_i), .msb_first_i(msb_first_i),
    .par_sel_i(par_sel_i), .data_o(data_o), .valid_o(valid_o),
    .par_err_o(par_err_o), .frame_err_o(frame_err_o)
  );

  always @(negedge clk_i) begin
    if (valid_o) begin
      got_n  <= got_n + 1;
      got_d  <= data_o;
      got_pe <= par_err_o;
      got_fe <= frame_err_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    repeat (3) @(negedge clk_i) tick_i = 1'b0;
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int nt, input bit glitch);
    for (int t = 1; t <= nt; t++) begin
      rxd_i = (glitch && (t <= 5 || t >= 11)) ? ~v : v;
      do_tick();
    end
  endtask

  function automatic logic model_par(input logic [8:0] d, input logic [2:0] pm);
    case (pm[1:0])
      2'd0: return ^d;
      2'd1: return ~^d;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // frame driver; config set on the ports before the start edge
  task automatic send_frame(input logic [8:0] d, input int n, input logic msb,
                            input logic [2:0] pm, input logic pbad, input logic stop_v,
                            input int stop_ticks, input bit glitch);
    nine_bit_i  = (n == 9);
    len_sel_i   = (n == 9) ? 2'd3 : 2'(n - 5);
    msb_first_i = msb;
    par_sel_i   = pm;
    send_bit(1'b0, 16, 1'b0);
    for (int i = 0; i < n; i++)
      send_bit(msb ? d[n-1-i] : d[i], 16, glitch);
    if (!pm[2]) send_bit(model_par(d, pm) ^ pbad, 16, glitch);
    send_bit(stop_v, stop_ticks, 1'b0);
  endtask

  task automatic expect_char(input string req, input int base, input logic [8:0] d,
                             input logic pe, input logic fe);
    repeat (2) @(negedge clk_i);
    check({req, " count"}, got_n, base + 1);
    check({req, " data"}, {23'd0, got_d}, {23'd0, d});
    check({req, " parity flag"}, {31'd0, got_pe}, {31'd0, pe});
    check({req, " framing flag"}, {31'd0, got_fe}, {31'd0, fe});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    logic [8:0] d;
    void'($urandom(32'h1c3f_5a07));
    repeat (4) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", {31'd0, valid_o}, 0);
    check("R1 data", {23'd0, data_o}, 0);
    check("R1 flags", {30'd0, par_err_o, frame_err_o}, 0);
    rst_ni = 1'b1;
    send_bit(1'b1, 20, 1'b0);

    // R4 R5 R6 directed: 8-bit lsb-first even
    base = got_n; send_frame(9'h0a5, 8, 1'b0, 3'd0, 1'b0, 1'b1, 16, 1'b0);
    expect_char("R5 lsb 8b even", base, 9'h0a5, 1'b0, 1'b0);
    // R5 msb-first 5-bit odd
    base = got_n; send_frame(9'h013, 5, 1'b1, 3'd1, 1'b0, 1'b1, 16, 1'b0);
    expect_char("R5 msb 5b odd", base, 9'h013, 1'b0, 1'b0);
    // R4 nine-bit, no parity
    base = got_n; send_frame(9'h1c6, 9, 1'b0, 3'd5, 1'b0, 1'b1, 16, 1'b0);
    expect_char("R4 9b none", base, 9'h1c6, 1'b0, 1'b0);
    // R6 forced one, corrupted
    base = got_n; send_frame(9'h02d, 6, 1'b0, 3'd3, 1'b1, 1'b1, 16, 1'b0);
    expect_char("R6 forced1 bad", base, 9'h02d, 1'b1, 1'b0);
    // R3 edge glitches ignored, centre sampled
    base = got_n; send_frame(9'h05a, 7, 1'b1, 3'd0, 1'b0, 1'b1, 16, 1'b1);
    expect_char("R3 centre", base, 9'h05a, 1'b0, 1'b0);

    // R2 false start: 7 low ticks then high
    base = got_n;
    send_bit(1'b0, 7, 1'b0);
    send_bit(1'b1, 200, 1'b0);
    check("R2 reject", got_n, base);

    // R8 short stop back to back
    base = got_n; send_frame(9'h0f0, 8, 1'b0, 3'd1, 1'b0, 1'b1, 9, 1'b0);
    expect_char("R8 first", base, 9'h0f0, 1'b0, 1'b0);
    base = got_n; send_frame(9'h00f, 8, 1'b0, 3'd1, 1'b0, 1'b1, 9, 1'b0);
    expect_char("R8 second", base, 9'h00f, 1'b0, 1'b0);

    // R7 R10 framing error, line held low
    base = got_n; send_frame(9'h033, 8, 1'b0, 3'd4, 1'b0, 1'b0, 16, 1'b0);
    expect_char("R7 framing", base, 9'h033, 1'b0, 1'b1);
    send_bit(1'b0, 400, 1'b0);
    check("R10 held low", got_n, base + 1);
    send_bit(1'b1, 16, 1'b0);
    base = got_n; send_frame(9'h081, 8, 1'b0, 3'd2, 1'b0, 1'b1, 16, 1'b0);
    expect_char("R10 recover", base, 9'h081, 1'b0, 1'b0);

    // random mix covering R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 60; k++) begin
      int n, st;
      logic msb, pb, sv;
      logic [2:0] pm;
      n   = 5 + int'($urandom % 5);
      d   = 9'($urandom) & 9'((1 << n) - 1);
      msb = 1'($urandom % 2);
      pm  = 3'($urandom % 8);
      pb  = (($urandom % 4) == 0) && !pm[2];
      sv  = (($urandom % 5) != 0);
      st  = 9 + int'($urandom % 8);
      base = got_n;
      send_frame(d, n, msb, pm, pb, sv, st, 1'b0);
      expect_char("R9 random", base, d, pb, !sv);
      if (!sv) send_bit(1'b1, 16, 1'b0);
      else if (($urandom % 3) == 0) send_bit(1'b1, 1 + int'($urandom % 20), 1'b0);
    end
    finish_run();
  end

endmodule